// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit logical address into a physical one by walking a three-level translation tree held in ordinary memory. A walk starts from one of two root pointers (one for supervisor accesses, one for user accesses). It reads a root-table entry, then a pointer-table entry, then a page entry. If the page entry is marked indirect, it also follows one more pointer. Each descriptor read goes over a simple 32-bit request/acknowledge memory port. The same port carries the write-backs that record in the tree that an entry was used, or that its page was modified.

A walk is launched by a one-cycle start pulse that carries the address and the access attributes: supervisor, instruction fetch, store, probe and debug. The page size, 4 KB or 8 KB, is selected for each walk. At the end the walker raises a one-cycle completion strobe with registered results: the physical address, the page size used, a write-permission bit, a fault flag with a cause code and, for probe walks, a status word that sums up what the walk found.

Top module: `ptw_walker`

## Requirements
- R1: The root base is `super_root` when `is_super` is set and `user_root` otherwise. The walker reads the root entry at {root[31:9], va[31:25], 00}, then the pointer entry at {rootdesc[31:9], va[24:18], 00}, then the page entry. `mem_addr` holds steady while a request waits for its acknowledge.
- R2: With `big_page` clear, the page entry is at {ptrdesc[31:8], va[17:12], 00} and the physical address is {pagedesc[31:12], va[11:0]}. With `big_page` set, the page entry is at {ptrdesc[31:7], va[17:13], 00} and the physical address is {pagedesc[31:13], va[12:0]}. `pg_big` reports the size that was used.
- R3: A root or pointer descriptor whose bit 1 is clear (type 0 or 1) is invalid. So is a page descriptor of type 0 (bits 1:0). Either ends the walk with `fault`=1 and cause 1, and the invalid entry is never written.
- R4: Bit 2 of any descriptor is write-protect, and it accumulates across levels. Write protection at any level, or an instruction fetch, gives `perm_wr`=0. A store that meets write protection ends with a fault of cause 2. A successful store always has `perm_wr`=1.
- R5: A valid root or pointer descriptor whose used bit (bit 3) is clear is written back to the same address with bit 3 set. This happens before its write-protect bit is acted on.
- R6: A store to a page that is not write-protected writes the page descriptor back with bits 4 (modified) and 3 (used) set, unless both are already set. Every other access writes back only bit 3, and only when it is clear.
- R7: A debug walk never writes to memory.
- R8: A page descriptor of type 2 is indirect. Its bits 31:2 address the real page descriptor, which is read once more and is then the descriptor that gets checked and written back.
- R9: A page descriptor with bit 7 set makes a user access end with a fault of cause 4'd3 (code 3). Supervisor accesses pass.
- R10: A memory error on any read or write aborts the walk with a fault of cause 4.
- R11: A probe walk that reaches a page descriptor loads `probe_status` with {pa[31:12], 0000, desc[7:3], accumulated write-protect, 0, 1}. A probe walk that stops earlier loads only bit 2, the accumulated write-protect. Walks that are not probes leave `probe_status` unchanged.
- R12: After reset every output is 0. `done` is high for exactly one cycle per walk. The result outputs hold their values until the next walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a walk (accepted when idle) |
| vaddr | input | 32 | Logical address |
| is_super | input | 1 | Supervisor access |
| is_code | input | 1 | Instruction fetch |
| is_store | input | 1 | Store access |
| is_probe | input | 1 | Probe walk, updates the status word |
| is_debug | input | 1 | Debug walk, no write-backs |
| user_root | input | 32 | User root table pointer |
| super_root | input | 32 | Supervisor root table pointer |
| big_page | input | 1 | 1 selects 8 KB pages, 0 selects 4 KB |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Bus error, valid with acknowledge |
| done | output | 1 | One-cycle walk completion |
| fault | output | 1 | Walk failed |
| cause | output | 3 | 0 none, 1 invalid, 2 write-protect, 3 supervisor-only, 4 bus error |
| phys_addr | output | 32 | Physical address (0 on fault) |
| pg_big | output | 1 | Page size used by the last walk |
| perm_wr | output | 1 | Write permitted |
| probe_status | output | 32 | Status word from the last probe walk |

## Verification
The translation path is tried with fresh trees in which every used bit is clear, with trees whose bits are already set, and under 4 KB and 8 KB sizes. Comparing the memory contents after the walk and the number of writes shows whether write-back happens at each level, and whether the modified bit is applied only to non-protected stores. Store, load, fetch, debug and probe variants of the same tree tell the permission and write-back rules apart. Broken trees (an invalid root, protection at the pointer level, a supervisor-only page, an error on the pointer read) each isolate one fault cause and its point of abort. An indirect tree shows whether the write-back lands on the final descriptor rather than on the pointer to it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned DW         = 32;
  localparam int unsigned IDX_W      = 7;
  localparam int unsigned ENT_LOG2   = 2;
  localparam int unsigned TBL_ALIGN  = IDX_W + ENT_LOG2;
  localparam int unsigned ROOT_LSB   = DW - IDX_W;
  localparam int unsigned PTR_LSB    = ROOT_LSB - IDX_W;
  localparam int unsigned PG_SH_S    = 12;
  localparam int unsigned PG_SH_L    = 13;
  localparam int unsigned PGI_W_S    = PTR_LSB - PG_SH_S;
  localparam int unsigned PGI_W_L    = PTR_LSB - PG_SH_L;
  localparam int unsigned STAT_LSB   = 12;

  localparam int unsigned B_WP    = 2;
  localparam int unsigned B_USED  = 3;
  localparam int unsigned B_MOD   = 4;
  localparam int unsigned B_SUPER = 7;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_INVALID = 3'd1,
    CAUSE_WPROT   = 3'd2,
    CAUSE_SUPER   = 3'd3,
    CAUSE_BUS     = 3'd4
  } cause_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ROOT, S_WB_ROOT, S_RD_PTR, S_WB_PTR, S_RD_PAGE, S_RD_IND, S_WB_PAGE
  } wstate_t;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
  import ptw_pkg::*;
(
  input  logic [1:0]    level,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] va,
  input  logic          big,
  output logic [DW-1:0] ent
);
  logic unused_bits;
  assign unused_bits = ^{base[ENT_LOG2+PGI_W_L-1:0], va[PG_SH_S-1:0]};

  always_comb begin
    unique case (level)
      2'd0: ent = {base[DW-1:TBL_ALIGN], va[DW-1:ROOT_LSB], {ENT_LOG2{1'b0}}};
      2'd1: ent = {base[DW-1:TBL_ALIGN], va[ROOT_LSB-1:PTR_LSB], {ENT_LOG2{1'b0}}};
      default: begin
        if (big)
          ent = {base[DW-1:PGI_W_L+ENT_LOG2], va[PTR_LSB-1:PG_SH_L], {ENT_LOG2{1'b0}}};
        else
          ent = {base[DW-1:PGI_W_S+ENT_LOG2], va[PTR_LSB-1:PG_SH_S], {ENT_LOG2{1'b0}}};
      end
    endcase
  end
endmodule

// File: rtl/ptw_page_eval.sv
module ptw_page_eval
  import ptw_pkg::*;
(
  input  logic [DW-1:0] desc,
  input  logic [DW-1:0] va,
  input  logic          big,
  input  logic          store,
  input  logic          debug,
  input  logic          sup,
  input  logic          code,
  input  logic          wp_upper,
  output logic          need_wb,
  output logic [DW-1:0] wb_val,
  output logic [DW-1:0] pa,
  output logic          flt,
  output cause_t        flt_cause,
  output logic          wr_ok,
  output logic [DW-1:0] status
);
  logic wp_all;
  logic unused_bits;
  assign unused_bits = ^{desc[1:0], desc[PG_SH_S-1:B_SUPER+1]};

  assign wp_all = wp_upper | desc[B_WP];

  always_comb begin
    if (store && !desc[B_WP]) begin
      need_wb = !(desc[B_MOD] && desc[B_USED]);
      wb_val  = desc | (DW'(1) << B_MOD) | (DW'(1) << B_USED);
    end else begin
      need_wb = !desc[B_USED];
      wb_val  = desc | (DW'(1) << B_USED);
    end
    if (debug) need_wb = 1'b0;
  end

  always_comb begin
    if (big) pa = {desc[DW-1:PG_SH_L], va[PG_SH_L-1:0]};
    else     pa = {desc[DW-1:PG_SH_S], va[PG_SH_S-1:0]};
  end

  always_comb begin
    flt       = 1'b0;
    flt_cause = CAUSE_NONE;
    if (store && wp_all) begin
      flt       = 1'b1;
      flt_cause = CAUSE_WPROT;
    end else if (desc[B_SUPER] && !sup) begin
      flt       = 1'b1;
      flt_cause = CAUSE_SUPER;
    end
  end

  assign wr_ok  = !wp_all && !code && !flt;
  assign status = {pa[DW-1:STAT_LSB], 4'b0000, desc[B_SUPER:B_USED], wp_all, 1'b0, 1'b1};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [31:0]   vaddr,
  input  logic          is_super,
  input  logic          is_code,
  input  logic          is_store,
  input  logic          is_probe,
  input  logic          is_debug,
  input  logic [31:0]   user_root,
  input  logic [31:0]   super_root,
  input  logic          big_page,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          done,
  output logic          fault,
  output logic [2:0]    cause,
  output logic [31:0]   phys_addr,
  output logic          pg_big,
  output logic          perm_wr,
  output logic [31:0]   probe_status
);
  wstate_t st, st_n;
  logic [DW-1:0] va_q, desc_q, addr_q, wdata_q;
  logic [DW-1:0] desc_n, addr_n, wdata_n;
  logic sup_q, code_q, store_q, probe_q, dbg_q, big_q, wp_q, wp_n;

  logic          is_rd;
  logic [DW-1:0] cur_desc;
  logic [1:0]    ag_level;
  logic [DW-1:0] ag_base, ag_va, ag_ent;
  logic          ag_big;

  logic          pe_need_wb, pe_flt, pe_wr_ok;
  logic [DW-1:0] pe_wb_val, pe_pa, pe_status;
  cause_t        pe_cause;

  logic          fin, fin_flt, fin_perm, descend, leaf, page_end;
  cause_t        fin_cause;
  logic [DW-1:0] fin_pa, fin_stat;

  assign is_rd    = (st == S_RD_ROOT) || (st == S_RD_PTR) || (st == S_RD_PAGE) || (st == S_RD_IND);
  assign cur_desc = is_rd ? mem_rdata : desc_q;

  always_comb begin
    if (st == S_IDLE)                               ag_level = 2'd0;
    else if ((st == S_RD_ROOT) || (st == S_WB_ROOT)) ag_level = 2'd1;
    else                                            ag_level = 2'd2;
  end
  assign ag_base = (st == S_IDLE) ? (is_super ? super_root : user_root) : cur_desc;
  assign ag_va   = (st == S_IDLE) ? vaddr : va_q;
  assign ag_big  = (st == S_IDLE) ? big_page : big_q;

  ptw_entry_addr u_addr (
    .level (ag_level),
    .base  (ag_base),
    .va    (ag_va),
    .big   (ag_big),
    .ent   (ag_ent)
  );

  ptw_page_eval u_page (
    .desc      (cur_desc),
    .va        (va_q),
    .big       (big_q),
    .store     (store_q),
    .debug     (dbg_q),
    .sup       (sup_q),
    .code      (code_q),
    .wp_upper  (wp_q),
    .need_wb   (pe_need_wb),
    .wb_val    (pe_wb_val),
    .pa        (pe_pa),
    .flt       (pe_flt),
    .flt_cause (pe_cause),
    .wr_ok     (pe_wr_ok),
    .status    (pe_status)
  );

  always_comb begin
    st_n      = st;
    addr_n    = addr_q;
    wdata_n   = wdata_q;
    desc_n    = desc_q;
    wp_n      = wp_q;
    fin       = 1'b0;
    fin_flt   = 1'b0;
    fin_cause = CAUSE_NONE;
    fin_pa    = '0;
    fin_perm  = 1'b0;
    fin_stat  = {{(DW-3){1'b0}}, wp_q, 2'b00};
    descend   = 1'b0;
    leaf      = 1'b0;
    page_end  = 1'b0;

    unique case (st)
      S_IDLE: begin
        if (start) begin
          st_n   = S_RD_ROOT;
          addr_n = ag_ent;
          wp_n   = 1'b0;
        end
      end
      S_RD_ROOT, S_RD_PTR: begin
        if (mem_ack) begin
          if (mem_err) begin
            fin = 1'b1; fin_flt = 1'b1; fin_cause = CAUSE_BUS;
          end else if (!mem_rdata[1]) begin
            fin = 1'b1; fin_flt = 1'b1; fin_cause = CAUSE_INVALID;
          end else begin
            desc_n = mem_rdata;
            if (!mem_rdata[B_USED] && !dbg_q) begin
              wdata_n = mem_rdata | (DW'(1) << B_USED);
              st_n    = (st == S_RD_ROOT) ? S_WB_ROOT : S_WB_PTR;
            end else begin
              descend = 1'b1;
            end
          end
        end
      end
      S_WB_ROOT, S_WB_PTR: begin
        if (mem_ack) begin
          if (mem_err) begin
            fin = 1'b1; fin_flt = 1'b1; fin_cause = CAUSE_BUS;
          end else begin
            descend = 1'b1;
          end
        end
      end
      S_RD_PAGE: begin
        if (mem_ack) begin
          if (mem_err) begin
            fin = 1'b1; fin_flt = 1'b1; fin_cause = CAUSE_BUS;
          end else if (mem_rdata[1:0] == 2'b00) begin
            fin = 1'b1; fin_flt = 1'b1; fin_cause = CAUSE_INVALID;
          end else if (mem_rdata[1:0] == 2'b10) begin
            addr_n = {mem_rdata[DW-1:ENT_LOG2], {ENT_LOG2{1'b0}}};
            st_n   = S_RD_IND;
          end else begin
            leaf = 1'b1;
          end
        end
      end
      S_RD_IND: begin
        if (mem_ack) begin
          if (mem_err) begin
            fin = 1'b1; fin_flt = 1'b1; fin_cause = CAUSE_BUS;
          end else begin
            leaf = 1'b1;
          end
        end
      end
      S_WB_PAGE: begin
        if (mem_ack) begin
          if (mem_err) begin
            fin = 1'b1; fin_flt = 1'b1; fin_cause = CAUSE_BUS;
          end else begin
            page_end = 1'b1;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase

    if (descend) begin
      wp_n = wp_q | cur_desc[B_WP];
      if (cur_desc[B_WP] && store_q) begin
        fin = 1'b1; fin_flt = 1'b1; fin_cause = CAUSE_WPROT;
        fin_stat = {{(DW-3){1'b0}}, 1'b1, 2'b00};
      end else begin
        addr_n = ag_ent;
        st_n   = ((st == S_RD_ROOT) || (st == S_WB_ROOT)) ? S_RD_PTR : S_RD_PAGE;
      end
    end

    if (leaf) begin
      desc_n = mem_rdata;
      if (pe_need_wb) begin
        wdata_n = pe_wb_val;
        st_n    = S_WB_PAGE;
      end else begin
        page_end = 1'b1;
      end
    end

    if (page_end) begin
      fin       = 1'b1;
      fin_flt   = pe_flt;
      fin_cause = pe_cause;
      fin_pa    = pe_flt ? '0 : pe_pa;
      fin_perm  = pe_wr_ok;
      fin_stat  = pe_status;
    end

    if (fin) st_n = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      va_q         <= '0;
      desc_q       <= '0;
      addr_q       <= '0;
      wdata_q      <= '0;
      wp_q         <= 1'b0;
      sup_q        <= 1'b0;
      code_q       <= 1'b0;
      store_q      <= 1'b0;
      probe_q      <= 1'b0;
      dbg_q        <= 1'b0;
      big_q        <= 1'b0;
      done         <= 1'b0;
      fault        <= 1'b0;
      cause        <= 3'd0;
      phys_addr    <= '0;
      pg_big       <= 1'b0;
      perm_wr      <= 1'b0;
      probe_status <= '0;
    end else begin
      st      <= st_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      desc_q  <= desc_n;
      wp_q    <= wp_n;
      done    <= fin;
      if ((st == S_IDLE) && start) begin
        va_q    <= vaddr;
        sup_q   <= is_super;
        code_q  <= is_code;
        store_q <= is_store;
        probe_q <= is_probe;
        dbg_q   <= is_debug;
        big_q   <= big_page;
      end
      if (fin) begin
        fault     <= fin_flt;
        cause     <= fin_cause;
        phys_addr <= fin_pa;
        perm_wr   <= fin_perm;
        pg_big    <= big_q;
        if (probe_q) probe_status <= fin_stat;
      end
    end
  end

  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WB_ROOT) || (st == S_WB_PTR) || (st == S_WB_PAGE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_DEBUG_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !dbg_q); // R7
  AST_WB_USED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[B_USED]); // R5
  AST_STORE_WRITABLE: assert property (@(posedge clk) disable iff (rst)
    (done && !fault && store_q) |-> perm_wr); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> $stable(mem_addr)); // R1
  AST_FAULT_CODED: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (cause != 3'd0)); // R3
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        start = 0, is_super = 0, is_code = 0, is_store = 0, is_probe = 0, is_debug = 0, big_page = 0;
  logic [31:0] vaddr = '0;
  logic [31:0] user_root = 32'h0001_0000;
  logic [31:0] super_root = 32'h0002_0000;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, fault, pg_big, perm_wr;
  logic [2:0]  cause;
  logic [31:0] phys_addr, probe_status;

  localparam logic [31:0] PT  = 32'h0003_0000;
  localparam logic [31:0] PG  = 32'h0004_0000;
  localparam logic [31:0] IND = 32'h0005_0010;
  localparam logic [31:0] VA  = 32'h1234_5678;

  int checks = 0, errors = 0, wr_cnt = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] mem [logic [31:0]];
  bit finished = 0;

  logic        r_fault, r_perm, r_big, r_after;
  logic [2:0]  r_cause;
  logic [31:0] r_pa, r_stat;

  ptw_walker u0 (
    .clk(clk), .rst(rst), .start(start), .vaddr(vaddr), .is_super(is_super),
    .is_code(is_code), .is_store(is_store), .is_probe(is_probe), .is_debug(is_debug),
    .user_root(user_root), .super_root(super_root), .big_page(big_page),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .done(done), .fault(fault), .cause(cause), .phys_addr(phys_addr),
    .pg_big(pg_big), .perm_wr(perm_wr), .probe_status(probe_status)
  );

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_err   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_err   <= (mem_addr == err_addr);
        mem_rdata <= mrd(mem_addr);
        if (mem_we && (mem_addr != err_addr)) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt = wr_cnt + 1;
        end
      end
    end
  end

  function automatic logic [31:0] root_ent(input logic [31:0] rp, input logic [31:0] va);
    return {rp[31:9], va[31:25], 2'b00};
  endfunction
  function automatic logic [31:0] ptr_ent(input logic [31:0] d, input logic [31:0] va);
    return {d[31:9], va[24:18], 2'b00};
  endfunction
  function automatic logic [31:0] pg_ent(input logic [31:0] d, input logic [31:0] va, input logic bg);
    return bg ? {d[31:7], va[17:13], 2'b00} : {d[31:8], va[17:12], 2'b00};
  endfunction
  function automatic logic [31:0] exp_pa(input logic [31:0] d, input logic [31:0] va, input logic bg);
    return bg ? {d[31:13], va[12:0]} : {d[31:12], va[11:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build(input logic [31:0] rp, input logic [31:0] rf, input logic [31:0] pf,
                       input logic [31:0] pgd, input logic bg);
    mem.delete();
    wr_cnt   = 0;
    err_addr = 32'hFFFF_FFFF;
    mem[root_ent(rp, VA)]     = PT | rf;
    mem[ptr_ent(PT, VA)]      = PG | pf;
    mem[pg_ent(PG, VA, bg)]   = pgd;
  endtask

  task automatic walk(input logic [31:0] va, input logic sp, input logic cd, input logic stv,
                      input logic pr, input logic dg, input logic bg);
    int n;
    @(negedge clk);
    vaddr = va; is_super = sp; is_code = cd; is_store = stv;
    is_probe = pr; is_debug = dg; big_page = bg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (!done) begin
      errors++;
      $display("FAIL R12 actual=no_done expected=done");
    end
    r_fault = fault; r_cause = cause; r_pa = phys_addr;
    r_perm = perm_wr; r_big = pg_big; r_stat = probe_status;
    @(negedge clk);
    r_after = done;
  endtask

  task automatic t_reset;
    chk("R12 done", {31'b0, done}, 0);
    chk("R12 req", {31'b0, mem_req}, 0);
    chk("R12 fault", {31'b0, fault}, 0);
    chk("R12 perm", {31'b0, perm_wr}, 0);
    chk("R12 status", probe_status, 0);
    chk("R12 pa", phys_addr, 0);
  endtask

  task automatic t_basic_load;
    build(user_root, 32'h2, 32'h2, 32'hABCD_E001, 1'b0);
    walk(VA, 0, 0, 0, 0, 0, 0);
    chk("R1 fault", {31'b0, r_fault}, 0);
    chk("R2 pa", r_pa, exp_pa(32'hABCD_E001, VA, 0));
    chk("R2 size", {31'b0, r_big}, 0);
    chk("R4 perm", {31'b0, r_perm}, 1);
    chk("R12 pulse", {31'b0, r_after}, 0);
    chk("R5 root used", mrd(root_ent(user_root, VA)), PT | 32'hA);
    chk("R5 ptr used", mrd(ptr_ent(PT, VA)), PG | 32'hA);
    chk("R6 load used only", mrd(pg_ent(PG, VA, 0)), 32'hABCD_E009);
    chk("R5 writes", wr_cnt, 3);
  endtask

  task automatic t_store_mod;
    build(user_root, 32'h2, 32'h2, 32'hABCD_E001, 1'b0);
    walk(VA, 0, 0, 1, 0, 0, 0);
    chk("R6 fault", {31'b0, r_fault}, 0);
    chk("R6 store mod+used", mrd(pg_ent(PG, VA, 0)), 32'hABCD_E019);
    chk("R4 store perm", {31'b0, r_perm}, 1);
  endtask

  task automatic t_already_set;
    build(user_root, 32'hA, 32'hA, 32'hABCD_E019, 1'b0);
    walk(VA, 0, 0, 1, 0, 0, 0);
    chk("R6 no rewrite", wr_cnt, 0);
    chk("R6 pa", r_pa, exp_pa(32'hABCD_E019, VA, 0));
    build(user_root, 32'hA, 32'hA, 32'hABCD_E011, 1'b0);
    walk(VA, 0, 0, 0, 0, 0, 0);
    chk("R6 load sets used only", mrd(pg_ent(PG, VA, 0)), 32'hABCD_E019);
    chk("R5 table set untouched", wr_cnt, 1);
  endtask

  task automatic t_debug;
    build(user_root, 32'h2, 32'h2, 32'hABCD_E001, 1'b0);
    walk(VA, 0, 0, 1, 0, 1, 0);
    chk("R7 no writes", wr_cnt, 0);
    chk("R7 pa", r_pa, exp_pa(32'hABCD_E001, VA, 0));
    chk("R7 page kept", mrd(pg_ent(PG, VA, 0)), 32'hABCD_E001);
  endtask

  task automatic t_big;
    build(user_root, 32'hA, 32'hA, 32'hABCD_F009, 1'b1);
    walk(VA, 0, 0, 0, 0, 0, 1);
    chk("R2 8k fault", {31'b0, r_fault}, 0);
    chk("R2 8k pa", r_pa, 32'hABCD_F678);
    chk("R2 8k size", {31'b0, r_big}, 1);
  endtask

  task automatic t_invalid;
    build(user_root, 32'h1, 32'h2, 32'hABCD_E001, 1'b0);
    walk(VA, 0, 0, 0, 0, 0, 0);
    chk("R3 fault", {31'b0, r_fault}, 1);
    chk("R3 cause", {29'b0, r_cause}, 1);
    chk("R3 no write", wr_cnt, 0);
    chk("R3 pa zero", r_pa, 0);
    build(user_root, 32'hA, 32'hA, 32'hABCD_E000, 1'b0);
    walk(VA, 0, 0, 0, 0, 0, 0);
    chk("R3 page invalid cause", {29'b0, r_cause}, 1);
  endtask

  task automatic t_wprot;
    build(user_root, 32'h2, 32'h6, 32'hABCD_E001, 1'b0);
    walk(VA, 0, 0, 0, 0, 0, 0);
    chk("R4 load ok", {31'b0, r_fault}, 0);
    chk("R4 perm off", {31'b0, r_perm}, 0);
    build(user_root, 32'h2, 32'h6, 32'hABCD_E001, 1'b0);
    walk(VA, 0, 0, 1, 0, 0, 0);
    chk("R4 store cause", {29'b0, r_cause}, 2);
    chk("R5 used before wp", mrd(ptr_ent(PT, VA)), PG | 32'hE);
    chk("R4 page untouched", mrd(pg_ent(PG, VA, 0)), 32'hABCD_E001);
    build(user_root, 32'hA, 32'hA, 32'hABCD_E00D, 1'b0);
    walk(VA, 0, 0, 1, 0, 0, 0);
    chk("R4 page wp store", {29'b0, r_cause}, 2);
    build(user_root, 32'hA, 32'hA, 32'hABCD_E009, 1'b0);
    walk(VA, 0, 1, 0, 0, 0, 0);
    chk("R4 fetch no write perm", {31'b0, r_perm}, 0);
  endtask

  task automatic t_super;
    build(user_root, 32'hA, 32'hA, 32'hABCD_E089, 1'b0);
    walk(VA, 0, 0, 0, 0, 0, 0);
    chk("R9 user cause", {29'b0, r_cause}, 3);
    build(super_root, 32'hA, 32'hA, 32'hABCD_E089, 1'b0);
    walk(VA, 1, 0, 0, 0, 0, 0);
    chk("R9 super ok", {31'b0, r_fault}, 0);
    chk("R1 super root", r_pa, exp_pa(32'hABCD_E089, VA, 0));
  endtask

  task automatic t_indirect;
    build(user_root, 32'hA, 32'hA, IND | 32'h2, 1'b0);
    mem[IND] = 32'h7654_3001;
    walk(VA, 0, 0, 0, 0, 0, 0);
    chk("R8 pa", r_pa, exp_pa(32'h7654_3001, VA, 0));
    chk("R8 target used", mrd(IND), 32'h7654_3009);
    chk("R8 pointer kept", mrd(pg_ent(PG, VA, 0)), IND | 32'h2);
  endtask

  task automatic t_bus;
    build(user_root, 32'h2, 32'h2, 32'hABCD_E001, 1'b0);
    err_addr = ptr_ent(PT, VA);
    walk(VA, 0, 0, 0, 0, 0, 0);
    chk("R10 fault", {31'b0, r_fault}, 1);
    chk("R10 cause", {29'b0, r_cause}, 4);
  endtask

  task automatic t_probe;
    build(super_root, 32'hA, 32'h6, 32'hABCD_E081, 1'b0);
    walk(VA, 1, 0, 0, 1, 0, 0);
    chk("R11 status", r_stat, 32'hABCD_E085);
    build(user_root, 32'h1, 32'h2, 32'hABCD_E001, 1'b0);
    walk(VA, 0, 0, 0, 1, 0, 0);
    chk("R11 early stop status", r_stat, 0);
    build(user_root, 32'hA, 32'hE, 32'hABCD_E009, 1'b0);
    walk(VA, 0, 0, 1, 1, 0, 0);
    chk("R11 wp stop status", r_stat, 32'h4);
    build(user_root, 32'hA, 32'hA, 32'h1111_1009, 1'b0);
    walk(VA, 0, 0, 0, 0, 0, 0);
    chk("R11 non-probe keeps status", probe_status, 32'h4);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R12 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_load();
    t_store_mod();
    t_already_set();
    t_debug();
    t_big();
    t_invalid();
    t_wprot();
    t_super();
    t_indirect();
    t_bus();
    t_probe();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule